// File: doc/BRIEF.md
# Register Consumer Tracking Table

This block sits in the decode stage of a core whose instruction window links instructions through forward pointers rather than through physical register tags. It keeps one row per architectural register. A row holds a busy flag, the window entry of the last in-flight writer of that register, and the chain tail. The chain tail is the window entry and operand slot that most recently referenced the register. While decode presents an instruction, the block looks up each source register combinationally. It returns the tail that dispatch must point at, or it reports that the value can be read from the architectural register file. On the clock edge it moves the tails for the instruction's sources and destination.

Commit clears the busy flag of a register when the committing entry is still that register's last writer. The block also keeps a fixed pool of snapshots of the whole table. A snapshot is taken on each predicted branch and restored on a misprediction. An exception flush empties both the table and the snapshot pool. Branches resolve in program order, so a correct resolution frees the oldest snapshot.

Top module: `reg_consumer_table`

## Requirements
- R1: After reset, every register looks up as non-busy, and the first snapshot identifier issued is 0.
- R2: An accepted instruction with a destination sets that register busy. Its writer becomes the instruction's entry and its tail becomes (entry, slot code 2 = destination).
- R3: A valid source that names a busy register returns the current tail (entry, slot) with busy high. On the edge, the tail moves to the reader's slot (code 0 = first source, code 1 = second source). Busy and writer stay unchanged.
- R4: A valid source that names a non-busy register returns busy low, and the table row is left unchanged.
- R5: When both sources name the same busy register, the second source returns (new entry, slot 0). The register's final tail is (new entry, slot 1).
- R6: When a source and the destination name the same register, the source lookup returns the tail from before the update. The final tail is the destination slot.
- R7: A commit clears busy only when the committing entry equals the recorded writer. A commit in the same cycle as a new write of that register leaves the register busy with the new writer.
- R8: An accepted predicted branch stores the table state that includes that branch's own updates. Snapshot identifiers are issued in ascending order from 0 after reset or flush, wrapping at the pool size.
- R9: A misprediction restores the table from the named snapshot and frees that snapshot and all younger ones. Decode is not accepted in that cycle.
- R10: A commit that clears a register's busy flag also clears it in every stored snapshot whose writer for that register matches.
- R11: A predicted branch is stalled (ready low, no effect on the table) while all snapshots are in use. A correct resolution frees the oldest snapshot.
- R12: A flush empties the table and frees every snapshot. It takes priority over decode and misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Exception flush: empty table and snapshot pool |
| dec_valid_i | input | 1 | Decode presents an instruction |
| dec_entry_i | input | PW | Window entry allocated to the instruction |
| dec_src1_vld_i | input | 1 | First source reads a register |
| dec_src1_reg_i | input | RW | First source register |
| dec_src2_vld_i | input | 1 | Second source reads a register |
| dec_src2_reg_i | input | RW | Second source register |
| dec_dst_vld_i | input | 1 | Instruction writes a register |
| dec_dst_reg_i | input | RW | Destination register |
| dec_branch_i | input | 1 | Instruction is a predicted branch |
| dec_ready_o | output | 1 | Instruction accepted this cycle |
| src1_busy_o | output | 1 | First source must link onto a chain |
| src1_tail_entry_o | output | PW | Entry at which the first source links |
| src1_tail_slot_o | output | 2 | Slot at which the first source links |
| src2_busy_o | output | 1 | Second source must link onto a chain |
| src2_tail_entry_o | output | PW | Entry at which the second source links |
| src2_tail_slot_o | output | 2 | Slot at which the second source links |
| ckpt_id_o | output | CW | Snapshot identifier given to a branch accepted this cycle |
| br_resolve_i | input | 1 | Oldest branch resolved as correctly predicted |
| br_mispredict_i | input | 1 | A branch was mispredicted |
| br_id_i | input | CW | Snapshot identifier of the mispredicted branch |
| commit_valid_i | input | 1 | An instruction commits |
| commit_entry_i | input | PW | Window entry of the committing instruction |
| commit_dst_vld_i | input | 1 | Committing instruction writes a register |
| commit_dst_reg_i | input | RW | Register written by the committing instruction |

## Verification
The assertions check the per-row rules on every cycle. These are: a destination write starts a chain, a busy row keeps its writer unless a write, commit, restore or flush touches it, and a matching commit clears busy. They also check that a flush leaves no busy row, that a full pool or a misprediction blocks decode, and that the snapshot count never exceeds the pool. Only the bench scenarios can show whole chains growing across several instructions, same-register forwarding within one instruction, the exact state a restore brings back, commit scrubbing inside stored snapshots, and the identifier order across stall, resolve and squash.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [1:0] {
    SLOT_SRC1 = 2'd0,
    SLOT_SRC2 = 2'd1,
    SLOT_DST  = 2'd2
  } slot_e;
endpackage

// File: rtl/rct_lookup.sv
module rct_lookup #(
  parameter int PW    = 7,
  parameter int RW    = 5,
  parameter int ROW_W = 2 * PW + 3
) (
  input  logic [ROW_W-1:0] row1_i,
  input  logic [ROW_W-1:0] row2_i,
  input  logic [PW-1:0]    entry_i,
  input  logic             src1_vld_i,
  input  logic [RW-1:0]    src1_reg_i,
  input  logic             src2_vld_i,
  input  logic [RW-1:0]    src2_reg_i,
  output logic             src1_busy_o,
  output logic [PW-1:0]    src1_ent_o,
  output logic [1:0]       src1_slot_o,
  output logic             src2_busy_o,
  output logic [PW-1:0]    src2_ent_o,
  output logic [1:0]       src2_slot_o
);
  import rct_pkg::*;

  typedef struct packed {
    logic          busy;
    logic [PW-1:0] writer;
    logic [PW-1:0] tail_ent;
    slot_e         tail_slot;
  } row_t;

  row_t r1, r2;
  logic same_reg;

  assign r1 = row_t'(row1_i);
  assign r2 = row_t'(row2_i);
  assign same_reg = src1_vld_i && src2_vld_i && (src1_reg_i == src2_reg_i);

  always_comb begin
    src1_busy_o = src1_vld_i && r1.busy;
    src1_ent_o  = r1.tail_ent;
    src1_slot_o = r1.tail_slot;
    src2_busy_o = src2_vld_i && r2.busy;
    src2_ent_o  = r2.tail_ent;
    src2_slot_o = r2.tail_slot;
    // second source chains behind the first when both read one busy register
    if (same_reg && r1.busy) begin
      src2_ent_o  = entry_i;
      src2_slot_o = SLOT_SRC1;
    end
  end
endmodule

// File: rtl/rct_row.sv
module rct_row #(
  parameter int PW      = 7,
  parameter int RW      = 5,
  parameter int ROW_IDX = 0,
  parameter int ROW_W   = 2 * PW + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             restore_i,
  input  logic [ROW_W-1:0] restore_row_i,
  input  logic             dec_acc_i,
  input  logic [PW-1:0]    dec_entry_i,
  input  logic             src1_vld_i,
  input  logic [RW-1:0]    src1_reg_i,
  input  logic             src2_vld_i,
  input  logic [RW-1:0]    src2_reg_i,
  input  logic             dst_vld_i,
  input  logic [RW-1:0]    dst_reg_i,
  input  logic             commit_i,
  input  logic [PW-1:0]    commit_entry_i,
  input  logic [RW-1:0]    commit_reg_i,
  output logic [ROW_W-1:0] row_q_o,
  output logic [ROW_W-1:0] row_d_o
);
  import rct_pkg::*;

  localparam logic [RW-1:0] IDX = RW'(ROW_IDX);

  typedef struct packed {
    logic          busy;
    logic [PW-1:0] writer;
    logic [PW-1:0] tail_ent;
    slot_e         tail_slot;
  } row_t;

  row_t q, upd, base, d;
  logic s1_hit, s2_hit, d_hit, cm_hit;

  assign s1_hit = dec_acc_i && src1_vld_i && (src1_reg_i == IDX);
  assign s2_hit = dec_acc_i && src2_vld_i && (src2_reg_i == IDX);
  assign d_hit  = dec_acc_i && dst_vld_i && (dst_reg_i == IDX);

  always_comb begin
    upd = q;
    if (d_hit) begin
      upd.busy      = 1'b1;
      upd.writer    = dec_entry_i;
      upd.tail_ent  = dec_entry_i;
      upd.tail_slot = SLOT_DST;
    end else if (q.busy && s2_hit) begin
      upd.tail_ent  = dec_entry_i;
      upd.tail_slot = SLOT_SRC2;
    end else if (q.busy && s1_hit) begin
      upd.tail_ent  = dec_entry_i;
      upd.tail_slot = SLOT_SRC1;
    end
  end

  assign base   = restore_i ? row_t'(restore_row_i) : upd;
  assign cm_hit = commit_i && (commit_reg_i == IDX) && base.busy &&
                  (base.writer == commit_entry_i);

  always_comb begin
    d = base;
    if (cm_hit) d.busy = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (flush_i) q <= '0;
    else              q <= d;
  end

  assign row_q_o = q;
  assign row_d_o = d;

  AST_DST_STARTS_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_hit && !flush_i && !(commit_i && commit_entry_i == dec_entry_i))
    |=> (q.busy && q.tail_slot == SLOT_DST && q.tail_ent == $past(dec_entry_i)
         && q.writer == $past(dec_entry_i))); // R2

  AST_BUSY_WRITER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.busy && !d_hit && !restore_i && !flush_i && !(commit_i && commit_reg_i == IDX))
    |=> (q.busy && q.writer == $past(q.writer))); // R3

  AST_COMMIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && commit_reg_i == IDX && q.busy && q.writer == commit_entry_i &&
     !d_hit && !restore_i && !flush_i)
    |=> !q.busy); // R7
endmodule

// File: rtl/rct_ckpt_alloc.sv
module rct_ckpt_alloc #(
  parameter int NUM_CKPT = 4,
  parameter int CW       = $clog2(NUM_CKPT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          alloc_i,
  input  logic          free_oldest_i,
  input  logic          squash_i,
  input  logic [CW-1:0] squash_id_i,
  output logic          full_o,
  output logic [CW-1:0] alloc_id_o
);
  logic [CW-1:0] head_q;
  logic [CW:0]   count_q;
  logic          do_free;
  logic [CW-1:0] squash_ofs;

  assign full_o     = (count_q == (CW + 1)'(NUM_CKPT));
  assign alloc_id_o = head_q + count_q[CW-1:0];
  assign do_free    = free_oldest_i && (count_q != '0);
  assign squash_ofs = squash_id_i - head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      count_q <= '0;
    end else if (squash_i) begin
      // the squashed snapshot and every younger one are released
      count_q <= {1'b0, squash_ofs};
    end else begin
      if (do_free) head_q <= head_q + 1'b1;
      count_q <= count_q + (CW + 1)'(alloc_i) - (CW + 1)'(do_free);
    end
  end

  AST_CKPT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= (CW + 1)'(NUM_CKPT)); // R11

  AST_NO_ALLOC_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !flush_i) |-> !full_o); // R11
endmodule

// File: rtl/rct_ckpt_store.sv
module rct_ckpt_store #(
  parameter int PW        = 7,
  parameter int RW        = 5,
  parameter int NUM_AREGS = 32,
  parameter int NUM_CKPT  = 4,
  parameter int CW        = $clog2(NUM_CKPT),
  parameter int ROW_W     = 2 * PW + 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            capture_i,
  input  logic [CW-1:0]                   cap_id_i,
  input  logic [NUM_AREGS-1:0][ROW_W-1:0] table_d_i,
  input  logic                            commit_i,
  input  logic [PW-1:0]                   commit_entry_i,
  input  logic [RW-1:0]                   commit_reg_i,
  input  logic [CW-1:0]                   rd_id_i,
  output logic [NUM_AREGS-1:0][ROW_W-1:0] rd_table_o
);
  localparam int BUSY_B = ROW_W - 1;

  logic [NUM_CKPT-1:0][NUM_AREGS-1:0][ROW_W-1:0] snap_q;

  for (genvar c = 0; c < NUM_CKPT; c++) begin : g_snap
    for (genvar r = 0; r < NUM_AREGS; r++) begin : g_reg
      logic scrub;
      assign scrub = commit_i && (commit_reg_i == RW'(r)) && snap_q[c][r][BUSY_B] &&
                     (snap_q[c][r][BUSY_B-1 -: PW] == commit_entry_i);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                snap_q[c][r] <= '0;
        else if (capture_i && cap_id_i == CW'(c))   snap_q[c][r] <= table_d_i[r];
        else if (scrub)                             snap_q[c][r][BUSY_B] <= 1'b0;
      end
    end
  end

  assign rd_table_o = snap_q[rd_id_i];
endmodule

// File: rtl/reg_consumer_table.sv
module reg_consumer_table #(
  parameter int NUM_AREGS   = 32,
  parameter int WIN_ENTRIES = 128,
  parameter int NUM_CKPT    = 4,
  parameter int PW          = $clog2(WIN_ENTRIES),
  parameter int RW          = $clog2(NUM_AREGS),
  parameter int CW          = $clog2(NUM_CKPT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          dec_valid_i,
  input  logic [PW-1:0] dec_entry_i,
  input  logic          dec_src1_vld_i,
  input  logic [RW-1:0] dec_src1_reg_i,
  input  logic          dec_src2_vld_i,
  input  logic [RW-1:0] dec_src2_reg_i,
  input  logic          dec_dst_vld_i,
  input  logic [RW-1:0] dec_dst_reg_i,
  input  logic          dec_branch_i,
  output logic          dec_ready_o,
  output logic          src1_busy_o,
  output logic [PW-1:0] src1_tail_entry_o,
  output logic [1:0]    src1_tail_slot_o,
  output logic          src2_busy_o,
  output logic [PW-1:0] src2_tail_entry_o,
  output logic [1:0]    src2_tail_slot_o,
  output logic [CW-1:0] ckpt_id_o,
  input  logic          br_resolve_i,
  input  logic          br_mispredict_i,
  input  logic [CW-1:0] br_id_i,
  input  logic          commit_valid_i,
  input  logic [PW-1:0] commit_entry_i,
  input  logic          commit_dst_vld_i,
  input  logic [RW-1:0] commit_dst_reg_i
);
  localparam int ROW_W  = 2 * PW + 3;
  localparam int BUSY_B = ROW_W - 1;

  logic [NUM_AREGS-1:0][ROW_W-1:0] rows_q, rows_d, snap_rd;
  logic [NUM_AREGS-1:0]            busy_vec;
  logic ckpt_full, dec_acc, restore, commit_w;

  assign dec_ready_o = !flush_i && !br_mispredict_i && !(dec_branch_i && ckpt_full);
  assign dec_acc     = dec_valid_i && dec_ready_o;
  assign restore     = br_mispredict_i && !flush_i;
  assign commit_w    = commit_valid_i && commit_dst_vld_i;

  for (genvar r = 0; r < NUM_AREGS; r++) begin : g_row
    rct_row #(.PW(PW), .RW(RW), .ROW_IDX(r), .ROW_W(ROW_W)) u_row (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .flush_i        (flush_i),
      .restore_i      (restore),
      .restore_row_i  (snap_rd[r]),
      .dec_acc_i      (dec_acc),
      .dec_entry_i    (dec_entry_i),
      .src1_vld_i     (dec_src1_vld_i),
      .src1_reg_i     (dec_src1_reg_i),
      .src2_vld_i     (dec_src2_vld_i),
      .src2_reg_i     (dec_src2_reg_i),
      .dst_vld_i      (dec_dst_vld_i),
      .dst_reg_i      (dec_dst_reg_i),
      .commit_i       (commit_w),
      .commit_entry_i (commit_entry_i),
      .commit_reg_i   (commit_dst_reg_i),
      .row_q_o        (rows_q[r]),
      .row_d_o        (rows_d[r])
    );
    assign busy_vec[r] = rows_q[r][BUSY_B];
  end

  rct_lookup #(.PW(PW), .RW(RW), .ROW_W(ROW_W)) u_lookup (
    .row1_i      (rows_q[dec_src1_reg_i]),
    .row2_i      (rows_q[dec_src2_reg_i]),
    .entry_i     (dec_entry_i),
    .src1_vld_i  (dec_src1_vld_i),
    .src1_reg_i  (dec_src1_reg_i),
    .src2_vld_i  (dec_src2_vld_i),
    .src2_reg_i  (dec_src2_reg_i),
    .src1_busy_o (src1_busy_o),
    .src1_ent_o  (src1_tail_entry_o),
    .src1_slot_o (src1_tail_slot_o),
    .src2_busy_o (src2_busy_o),
    .src2_ent_o  (src2_tail_entry_o),
    .src2_slot_o (src2_tail_slot_o)
  );

  rct_ckpt_alloc #(.NUM_CKPT(NUM_CKPT), .CW(CW)) u_alloc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .alloc_i       (dec_acc && dec_branch_i),
    .free_oldest_i (br_resolve_i),
    .squash_i      (restore),
    .squash_id_i   (br_id_i),
    .full_o        (ckpt_full),
    .alloc_id_o    (ckpt_id_o)
  );

  rct_ckpt_store #(.PW(PW), .RW(RW), .NUM_AREGS(NUM_AREGS), .NUM_CKPT(NUM_CKPT),
                   .CW(CW), .ROW_W(ROW_W)) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_i      (dec_acc && dec_branch_i),
    .cap_id_i       (ckpt_id_o),
    .table_d_i      (rows_d),
    .commit_i       (commit_w),
    .commit_entry_i (commit_entry_i),
    .commit_reg_i   (commit_dst_reg_i),
    .rd_id_i        (br_id_i),
    .rd_table_o     (snap_rd)
  );

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_vec == '0)); // R12

  AST_STALL_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_branch_i && ckpt_full) |-> !dec_ready_o); // R11

  AST_MISPREDICT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_mispredict_i |-> !dec_ready_o); // R9
endmodule

// File: tb/reg_consumer_table_tb.sv
module reg_consumer_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 7;
  localparam int RW = 5;
  localparam int CW = 2;
  localparam int S1 = 0, S2 = 1, SD = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i, dec_valid_i, dec_src1_vld_i, dec_src2_vld_i, dec_dst_vld_i, dec_branch_i;
  logic [PW-1:0] dec_entry_i, commit_entry_i;
  logic [RW-1:0] dec_src1_reg_i, dec_src2_reg_i, dec_dst_reg_i, commit_dst_reg_i;
  logic dec_ready_o, src1_busy_o, src2_busy_o;
  logic [PW-1:0] src1_tail_entry_o, src2_tail_entry_o;
  logic [1:0] src1_tail_slot_o, src2_tail_slot_o;
  logic [CW-1:0] ckpt_id_o, br_id_i;
  logic br_resolve_i, br_mispredict_i, commit_valid_i, commit_dst_vld_i;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  reg_consumer_table dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; dec_valid_i = 0; dec_entry_i = '0;
    dec_src1_vld_i = 0; dec_src1_reg_i = '0; dec_src2_vld_i = 0; dec_src2_reg_i = '0;
    dec_dst_vld_i = 0; dec_dst_reg_i = '0; dec_branch_i = 0;
    br_resolve_i = 0; br_mispredict_i = 0; br_id_i = '0;
    commit_valid_i = 0; commit_entry_i = '0; commit_dst_vld_i = 0; commit_dst_reg_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1; idle();
  endtask

  task automatic dec(input int ent, input bit s1v, input int s1, input bit s2v, input int s2,
                     input bit dv, input int dr, input bit br);
    dec_valid_i = 1; dec_entry_i = PW'(ent);
    dec_src1_vld_i = s1v; dec_src1_reg_i = RW'(s1);
    dec_src2_vld_i = s2v; dec_src2_reg_i = RW'(s2);
    dec_dst_vld_i = dv; dec_dst_reg_i = RW'(dr); dec_branch_i = br;
    #1;
  endtask

  task automatic commit(input int ent, input int r);
    commit_valid_i = 1; commit_entry_i = PW'(ent); commit_dst_vld_i = 1; commit_dst_reg_i = RW'(r);
  endtask

  task automatic look(input int r, input bit eb, input int ee, input int es, input string req);
    dec_src1_vld_i = 1; dec_src1_reg_i = RW'(r); #1;
    chk({req, " busy"}, int'(src1_busy_o), int'(eb));
    if (eb) begin
      chk({req, " tail entry"}, int'(src1_tail_entry_o), ee);
      chk({req, " tail slot"}, int'(src1_tail_slot_o), es);
    end
    idle(); #1;
  endtask

  task automatic do_flush();
    flush_i = 1; tick();
  endtask

  task automatic t_reset();
    look(0, 0, 0, 0, "R1 r0");
    look(31, 0, 0, 0, "R1 r31");
    chk("R1 first id", int'(ckpt_id_o), 0);
  endtask

  task automatic t_chain();
    dec(5, 0, 0, 0, 0, 1, 3, 0); tick();
    look(3, 1, 5, SD, "R2");
    dec(6, 1, 3, 0, 0, 0, 0, 0);
    chk("R3 src1 busy", int'(src1_busy_o), 1);
    chk("R3 src1 ent", int'(src1_tail_entry_o), 5);
    chk("R3 src1 slot", int'(src1_tail_slot_o), SD);
    tick(); look(3, 1, 6, S1, "R3 moved to src1");
    dec(7, 0, 0, 1, 3, 0, 0, 0);
    chk("R3 src2 ent", int'(src2_tail_entry_o), 6);
    chk("R3 src2 slot", int'(src2_tail_slot_o), S1);
    tick(); look(3, 1, 7, S2, "R3 moved to src2");
    dec(8, 1, 9, 0, 0, 0, 0, 0);
    chk("R4 nonbusy src", int'(src1_busy_o), 0);
    tick(); look(9, 0, 0, 0, "R4 row unchanged");
    look(3, 1, 7, S2, "R4 other row unchanged");
    dec(10, 1, 3, 1, 3, 0, 0, 0);
    chk("R5 src1 ent", int'(src1_tail_entry_o), 7);
    chk("R5 src2 busy", int'(src2_busy_o), 1);
    chk("R5 src2 ent", int'(src2_tail_entry_o), 10);
    chk("R5 src2 slot", int'(src2_tail_slot_o), S1);
    tick(); look(3, 1, 10, S2, "R5 final tail");
    dec(11, 1, 3, 0, 0, 1, 3, 0);
    chk("R6 src ent pre-update", int'(src1_tail_entry_o), 10);
    chk("R6 src slot pre-update", int'(src1_tail_slot_o), S2);
    tick(); look(3, 1, 11, SD, "R6 final tail");
  endtask

  task automatic t_commit();
    commit(5, 3); tick();
    look(3, 1, 11, SD, "R7 stale writer");
    commit(11, 3); tick();
    look(3, 0, 0, 0, "R7 writer clears");
    dec(12, 0, 0, 0, 0, 1, 2, 0); tick();
    commit(12, 2); dec(13, 0, 0, 0, 0, 1, 2, 0); tick();
    look(2, 1, 13, SD, "R7 same-cycle rewrite");
  endtask

  task automatic t_restore();
    do_flush();
    dec(20, 0, 0, 0, 0, 1, 4, 0); tick();
    dec(21, 1, 4, 0, 0, 0, 0, 1);
    chk("R8 id", int'(ckpt_id_o), 0);
    chk("R8 ready", int'(dec_ready_o), 1);
    tick();
    dec(22, 0, 0, 0, 0, 1, 4, 0); tick();
    dec(23, 0, 0, 0, 0, 1, 5, 0); tick();
    look(4, 1, 22, SD, "R9 pre-restore");
    br_mispredict_i = 1; br_id_i = '0; dec(24, 0, 0, 0, 0, 1, 6, 0);
    chk("R9 decode blocked", int'(dec_ready_o), 0);
    tick();
    look(4, 1, 21, S1, "R8 snapshot holds branch update");
    look(5, 0, 0, 0, "R9 younger write undone");
    look(6, 0, 0, 0, "R9 blocked decode no effect");
    dec(25, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 freed id reused", int'(ckpt_id_o), 0);
    tick();
  endtask

  task automatic t_scrub();
    do_flush();
    dec(30, 0, 0, 0, 0, 1, 6, 0); tick();
    dec(31, 0, 0, 0, 0, 0, 0, 1); tick();
    commit(30, 6); tick();
    look(6, 0, 0, 0, "R10 live clear");
    dec(32, 0, 0, 0, 0, 1, 6, 0); tick();
    br_mispredict_i = 1; br_id_i = '0; tick();
    look(6, 0, 0, 0, "R10 snapshot scrubbed");
  endtask

  task automatic t_stall();
    do_flush();
    for (int i = 0; i < 4; i++) begin
      dec(40 + i, 0, 0, 0, 0, 0, 0, 1);
      chk("R8 ascending id", int'(ckpt_id_o), i);
      tick();
    end
    dec(44, 0, 0, 0, 0, 1, 7, 1);
    chk("R11 stall when full", int'(dec_ready_o), 0);
    tick();
    look(7, 0, 0, 0, "R11 stalled no effect");
    br_resolve_i = 1; tick();
    dec(45, 0, 0, 0, 0, 0, 0, 1);
    chk("R11 ready after resolve", int'(dec_ready_o), 1);
    chk("R8 wrapped id", int'(ckpt_id_o), 0);
    tick();
    br_mispredict_i = 1; br_id_i = 2'd1; tick();
    for (int i = 0; i < 4; i++) begin
      dec(50 + i, 0, 0, 0, 0, 0, 0, 1);
      chk("R9 all freed ready", int'(dec_ready_o), 1);
      chk("R9 id after squash", int'(ckpt_id_o), (1 + i) % 4);
      tick();
    end
  endtask

  task automatic t_flush();
    dec(60, 0, 0, 0, 0, 1, 8, 0); tick();
    look(8, 1, 60, SD, "R12 setup");
    flush_i = 1; br_mispredict_i = 1; br_id_i = 2'd1;
    dec(61, 0, 0, 0, 0, 1, 9, 0);
    chk("R12 flush blocks decode", int'(dec_ready_o), 0);
    tick();
    look(8, 0, 0, 0, "R12 table empty");
    look(9, 0, 0, 0, "R12 decode dropped");
    dec(62, 0, 0, 0, 0, 0, 0, 1);
    chk("R12 pool freed", int'(ckpt_id_o), 0);
    chk("R12 ready", int'(dec_ready_o), 1);
    tick();
  endtask

  initial begin
    idle();
    #(CLK_PERIOD * 2 + 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_chain();
    t_commit();
    t_restore();
    t_scrub();
    t_stall();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule